// File: doc/BRIEF.md
# Hypervisor Mode Privilege Checker

This block sits beside the instruction decoder of a processor core that has a third privilege level, available only in the non-secure world. It keeps the current processor mode and the current security state in registers. Each cycle it looks at one event and reports whether that event is legal, UNDEFINED or UNPREDICTABLE. The event is a decoded instruction class, an exception-entry request or an exception-return request. For exception-raising events it also resolves the mode the core must enter.

The secure configuration register supplies two control bits: a non-secure bit and a hypervisor-call enable bit. Accepted entries and returns move the mode and security registers on the next clock edge. Flagged requests and plain instructions leave those registers as they are. The current privilege level is decoded from the mode register.

Top module: `mode_guard`

## Requirements
- R1: A synchronous active-high reset puts the block in secure state (`cur_ns`=0) and Supervisor mode 0b10011, with `priv`=1.
- R2: The mode encodings are User 0b10000, FIQ 0b10001, IRQ 0b10010, Supervisor 0b10011, Monitor 0b10110, Abort 0b10111, Hyp 0b11010, Undefined 0b11011 and System 0b11111. `priv` is 2 in Hyp, 0 in User and 1 in every other mode.
- R3: A hypervisor call (class bit 0) resolves to Hyp. It is UNDEFINED in secure state, in User mode, or in a non-secure PL1 mode while the enable bit is 0. It is UNPREDICTABLE in Hyp while the enable bit is 0. Otherwise it is legal.
- R4: A supervisor call (class bit 1) is always legal. It resolves to Hyp when issued in Hyp and to Supervisor everywhere else.
- R5: In Hyp mode the following are UNDEFINED: store-return-state (bit 2), return-from-exception (bit 3), exception-return load-multiple (bit 4), user-register load-multiple (bit 5), user-register store-multiple (bit 6), and subtract-PC-from-link with a nonzero immediate (bit 7, `subs_imm_zero`=0). Bit 7 with a zero immediate is legal. All of these are legal outside Hyp.
- R6: Unprivileged load/store (class bit 8) is UNPREDICTABLE in Hyp and legal elsewhere.
- R7: An exception entry must target FIQ, IRQ, Supervisor, Monitor, Abort, Undefined or Hyp; any other target is UNPREDICTABLE. While in Hyp, every target other than Monitor resolves to Hyp. An entry that resolves to Hyp from outside Hyp is legal only in non-secure state. An entry to Monitor makes the state secure.
- R8: An exception return to Hyp is UNPREDICTABLE in any of these cases: the configuration non-secure bit is 0, the return is made from a non-secure PL1 mode, or the resulting state would be secure.
- R9: An exception return from User, or to an unknown encoding, is UNPREDICTABLE. So is a return to Monitor whose resulting state is non-secure. A return from Monitor takes its security state from the configuration non-secure bit; any other return keeps the current state.
- R10: The mode and security registers change only on the edge after an accepted entry or return, taking the resolved target. Flagged requests and instructions leave them unchanged.
- R11: At most one of `legal`, `undef`, `unpred` is high. More than one event in a cycle is UNPREDICTABLE. No event raises no flag. When the event is neither an exception nor a request, `tgt_mode` equals `cur_mode`.
- R12: Hyp mode is never reached in secure state. An entry to Hyp attempted from secure state is UNPREDICTABLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ns | input | 1 | Non-secure bit of the secure configuration register |
| cfg_hce | input | 1 | Hypervisor-call enable bit of the secure configuration register |
| insn_cls | input | 9 | One-hot decoded instruction class, zero when no instruction |
| subs_imm_zero | input | 1 | Immediate of subtract-PC-from-link is zero |
| exc_entry | input | 1 | Exception-entry request |
| exc_return | input | 1 | Exception-return request |
| req_mode | input | 5 | Requested target mode of the entry or return |
| priv | output | 2 | Current privilege level |
| cur_mode | output | 5 | Current mode register |
| cur_ns | output | 1 | Current security state, 1 = non-secure |
| legal | output | 1 | Event is legal |
| undef | output | 1 | Event is UNDEFINED |
| unpred | output | 1 | Event is UNPREDICTABLE |
| tgt_mode | output | 5 | Resolved target mode |

## Verification
The assertions check four things on every cycle: the three verdict flags stay mutually exclusive, Hyp never coexists with secure state, the mode register always holds a known encoding, and Hyp is reached only from non-secure state or from Monitor. They also check that a flagged request, or any instruction, leaves the mode and security registers untouched, and that a hypervisor call from User is never legal. Only the bench's scenarios can show the exact verdict for each mode, class and control-bit combination. The same holds for the Hyp redirection of entries and supervisor calls, and for the security state that a Monitor return takes from the configuration bit.

// File: rtl/mg_pkg.sv
package mg_pkg;
    localparam int MODE_W = 5;
    localparam int NCLS   = 9;
    localparam int PRIV_W = 2;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_MON = 5'b10110,
        M_ABT = 5'b10111,
        M_HYP = 5'b11010,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [PRIV_W-1:0] {
        PL0 = 2'd0,
        PL1 = 2'd1,
        PL2 = 2'd2
    } priv_e;

    // instruction class bit positions
    localparam int C_HVC  = 0;
    localparam int C_SVC  = 1;
    localparam int C_SRS  = 2;
    localparam int C_RFE  = 3;
    localparam int C_LDMX = 4;
    localparam int C_LDMU = 5;
    localparam int C_STMU = 6;
    localparam int C_SUBS = 7;
    localparam int C_ULS  = 8;

    typedef struct packed {
        logic legal;
        logic undef;
        logic unpred;
    } verdict_t;

    localparam verdict_t V_NONE   = 3'b000;
    localparam verdict_t V_LEGAL  = 3'b100;
    localparam verdict_t V_UNDEF  = 3'b010;
    localparam verdict_t V_UNPRED = 3'b001;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_MON,
            M_ABT, M_HYP, M_UND, M_SYS: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic logic exc_target(input logic [MODE_W-1:0] m);
        return mode_known(m) && (m != M_USR) && (m != M_SYS);
    endfunction

    function automatic priv_e priv_of(input logic [MODE_W-1:0] m);
        if (m == M_HYP)      return PL2;
        else if (m == M_USR) return PL0;
        else                 return PL1;
    endfunction
endpackage

// File: rtl/mg_state.sv
module mg_state
    import mg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [MODE_W-1:0] nxt_mode,
    input  logic              nxt_ns,
    output logic [MODE_W-1:0] mode_q,
    output logic              ns_q
);
    logic in_hyp;
    assign in_hyp = (mode_q == M_HYP);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_SVC;
            ns_q   <= 1'b0;
        end else if (upd) begin
            mode_q <= nxt_mode;
            ns_q   <= nxt_ns;
        end
    end

    // Hyp exists only in non-secure state
    assert_hyp_nonsecure_R12: assert property (@(posedge clk) disable iff (rst)
        in_hyp |-> ns_q);

    // register never holds an unknown encoding
    assert_mode_known_R2: assert property (@(posedge clk) disable iff (rst)
        mode_known(mode_q));

    // Hyp reached only from non-secure state or from Monitor
    assert_hyp_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_hyp) |-> ($past(ns_q) || ($past(mode_q) == M_MON)));
endmodule

// File: rtl/mg_insn_rules.sv
module mg_insn_rules
    import mg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              ns,
    input  logic              hce,
    input  logic [NCLS-1:0]   cls,
    input  logic              imm_zero,
    output verdict_t          v,
    output logic [MODE_W-1:0] tgt
);
    logic  in_hyp;
    priv_e pl;
    logic  hyp_forbidden;

    assign in_hyp = (mode == M_HYP);
    assign pl     = priv_of(mode);
    assign hyp_forbidden = cls[C_SRS] | cls[C_RFE] | cls[C_LDMX] |
                           cls[C_LDMU] | cls[C_STMU];

    always_comb begin
        v   = V_LEGAL;
        tgt = mode;
        if (cls[C_HVC]) begin
            tgt = M_HYP;
            if (!ns || pl == PL0)
                v = V_UNDEF;
            else if (!hce)
                v = in_hyp ? V_UNPRED : V_UNDEF;
        end else if (cls[C_SVC]) begin
            tgt = in_hyp ? M_HYP : M_SVC;
        end else if (hyp_forbidden) begin
            if (in_hyp) v = V_UNDEF;
        end else if (cls[C_SUBS]) begin
            if (in_hyp && !imm_zero) v = V_UNDEF;
        end else if (cls[C_ULS]) begin
            if (in_hyp) v = V_UNPRED;
        end else begin
            v = V_NONE;
        end
    end

    // a hypervisor call from User is never accepted
    assert_hvc_user_R3: assert property (@(posedge clk) disable iff (rst)
        (cls[C_HVC] && mode == M_USR) |-> !v.legal);
endmodule

// File: rtl/mg_xfer_rules.sv
module mg_xfer_rules
    import mg_pkg::*;
(
    input  logic              is_entry,
    input  logic [MODE_W-1:0] mode,
    input  logic              ns,
    input  logic              cfg_ns,
    input  logic [MODE_W-1:0] req,
    output verdict_t          v,
    output logic [MODE_W-1:0] tgt,
    output logic              nxt_ns
);
    logic in_hyp;
    assign in_hyp = (mode == M_HYP);

    always_comb begin
        v = V_LEGAL;
        if (is_entry) begin
            tgt    = (in_hyp && req != M_MON) ? M_HYP : req;
            nxt_ns = (tgt == M_MON) ? 1'b0 : ns;
            if (!exc_target(req))
                v = V_UNPRED;
            else if (tgt == M_HYP && !in_hyp && !ns)
                v = V_UNPRED;
        end else begin
            tgt    = req;
            nxt_ns = (mode == M_MON) ? cfg_ns : ns;
            if (mode == M_USR || !mode_known(req))
                v = V_UNPRED;
            else if (req == M_HYP && (!cfg_ns || (ns && !in_hyp) || !nxt_ns))
                v = V_UNPRED;
            else if (req == M_MON && nxt_ns)
                v = V_UNPRED;
        end
    end
endmodule

// File: rtl/mode_guard.sv
module mode_guard
    import mg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ns,
    input  logic              cfg_hce,
    input  logic [NCLS-1:0]   insn_cls,
    input  logic              subs_imm_zero,
    input  logic              exc_entry,
    input  logic              exc_return,
    input  logic [MODE_W-1:0] req_mode,
    output logic [PRIV_W-1:0] priv,
    output logic [MODE_W-1:0] cur_mode,
    output logic              cur_ns,
    output logic              legal,
    output logic              undef,
    output logic              unpred,
    output logic [MODE_W-1:0] tgt_mode
);
    verdict_t          iv, xv, vd;
    logic [MODE_W-1:0] it, xt;
    logic              x_ns;
    logic              multi;
    logic              req_any;
    logic              upd;

    assign multi   = ($countones({insn_cls, exc_entry, exc_return}) > 1);
    assign req_any = exc_entry | exc_return;

    mg_state u_state (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .nxt_mode (tgt_mode),
        .nxt_ns   (x_ns),
        .mode_q   (cur_mode),
        .ns_q     (cur_ns)
    );

    mg_insn_rules u_insn (
        .clk      (clk),
        .rst      (rst),
        .mode     (cur_mode),
        .ns       (cur_ns),
        .hce      (cfg_hce),
        .cls      (insn_cls),
        .imm_zero (subs_imm_zero),
        .v        (iv),
        .tgt      (it)
    );

    mg_xfer_rules u_xfer (
        .is_entry (exc_entry),
        .mode     (cur_mode),
        .ns       (cur_ns),
        .cfg_ns   (cfg_ns),
        .req      (req_mode),
        .v        (xv),
        .tgt      (xt),
        .nxt_ns   (x_ns)
    );

    always_comb begin
        if (multi) begin
            vd       = V_UNPRED;
            tgt_mode = cur_mode;
        end else if (req_any) begin
            vd       = xv;
            tgt_mode = xt;
        end else begin
            vd       = iv;
            tgt_mode = it;
        end
    end

    assign upd    = req_any && !multi && vd.legal;
    assign legal  = vd.legal;
    assign undef  = vd.undef;
    assign unpred = vd.unpred;
    assign priv   = priv_of(cur_mode);

    assert_one_verdict_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({legal, undef, unpred}));

    assert_flagged_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (req_any && !legal) |=> ($stable(cur_mode) && $stable(cur_ns)));

    assert_insn_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ((|insn_cls) && !req_any) |=> ($stable(cur_mode) && $stable(cur_ns)));
endmodule

// File: tb/mode_guard_test.sv
module mode_guard_test;
    import mg_pkg::*;

    localparam logic [NCLS-1:0] K_NO   = 9'b000000000;
    localparam logic [NCLS-1:0] K_HVC  = 9'b000000001;
    localparam logic [NCLS-1:0] K_SVC  = 9'b000000010;
    localparam logic [NCLS-1:0] K_SRS  = 9'b000000100;
    localparam logic [NCLS-1:0] K_RFE  = 9'b000001000;
    localparam logic [NCLS-1:0] K_LDMX = 9'b000010000;
    localparam logic [NCLS-1:0] K_LDMU = 9'b000100000;
    localparam logic [NCLS-1:0] K_STMU = 9'b001000000;
    localparam logic [NCLS-1:0] K_SUBS = 9'b010000000;
    localparam logic [NCLS-1:0] K_ULS  = 9'b100000000;
    localparam logic [2:0] F_N = 3'b000, F_L = 3'b100, F_U = 3'b010, F_P = 3'b001;
    localparam logic O = 1'b0, I = 1'b1;
    localparam logic [4:0] M_BAD = 5'b10100;

    typedef struct packed {
        logic              ns;
        logic              hce;
        logic [NCLS-1:0]   cls;
        logic              imm0;
        logic              ent;
        logic              ret;
        logic [MODE_W-1:0] req;
        logic [2:0]        fl;
        logic [MODE_W-1:0] tgt;
        logic [MODE_W-1:0] m_after;
        logic              ns_after;
        logic [3:0]        tag;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [NV] = '{
        '{O,O,K_HVC ,O,O,O,M_SVC, F_U,M_HYP,M_SVC,O,4'd3},  // R3 secure
        '{O,O,K_NO  ,O,O,I,M_HYP, F_P,M_HYP,M_SVC,O,4'd8},  // R8 cfg ns 0
        '{O,O,K_NO  ,O,I,O,M_MON, F_L,M_MON,M_MON,O,4'd7},  // R7
        '{I,O,K_NO  ,O,O,I,M_HYP, F_L,M_HYP,M_HYP,I,4'd8},  // R8 from Monitor
        '{I,O,K_SVC ,O,O,O,M_SVC, F_L,M_HYP,M_HYP,I,4'd4},  // R4
        '{I,O,K_HVC ,O,O,O,M_SVC, F_P,M_HYP,M_HYP,I,4'd3},  // R3
        '{I,I,K_HVC ,O,O,O,M_SVC, F_L,M_HYP,M_HYP,I,4'd3},  // R3
        '{I,O,K_SRS ,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},  // R5
        '{I,O,K_RFE ,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_LDMX,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_LDMU,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_STMU,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_SUBS,O,O,O,M_SVC, F_U,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_SUBS,I,O,O,M_SVC, F_L,M_HYP,M_HYP,I,4'd5},
        '{I,O,K_ULS ,O,O,O,M_SVC, F_P,M_HYP,M_HYP,I,4'd6},  // R6
        '{I,O,K_NO  ,O,I,O,M_SVC, F_L,M_HYP,M_HYP,I,4'd7},  // R7 redirect
        '{I,O,K_NO  ,O,O,I,M_SVC, F_L,M_SVC,M_SVC,I,4'd9},  // R9
        '{I,O,K_HVC ,O,O,O,M_SVC, F_U,M_HYP,M_SVC,I,4'd3},
        '{I,I,K_HVC ,O,O,O,M_SVC, F_L,M_HYP,M_SVC,I,4'd3},
        '{I,O,K_NO  ,O,O,I,M_HYP, F_P,M_HYP,M_SVC,I,4'd8},  // R8 from NS PL1
        '{I,O,K_SRS ,O,O,O,M_SVC, F_L,M_SVC,M_SVC,I,4'd5},
        '{I,O,K_ULS ,O,O,O,M_SVC, F_L,M_SVC,M_SVC,I,4'd6},
        '{I,O,K_SVC ,O,O,O,M_SVC, F_L,M_SVC,M_SVC,I,4'd4},
        '{I,O,K_NO  ,O,I,O,M_USR, F_P,M_USR,M_SVC,I,4'd7},
        '{I,O,K_NO  ,O,O,I,M_USR, F_L,M_USR,M_USR,I,4'd9},
        '{I,I,K_HVC ,O,O,O,M_SVC, F_U,M_HYP,M_USR,I,4'd3},
        '{I,O,K_NO  ,O,O,I,M_SVC, F_P,M_SVC,M_USR,I,4'd9},
        '{I,O,K_NO  ,O,I,O,M_HYP, F_L,M_HYP,M_HYP,I,4'd7},
        '{I,O,K_NO  ,O,O,I,M_BAD, F_P,M_BAD,M_HYP,I,4'd9},
        '{I,O,K_HVC|K_SVC,O,O,O,M_SVC, F_P,M_HYP,M_HYP,I,4'd11},  // R11
        '{I,O,K_NO  ,O,I,I,M_IRQ, F_P,M_HYP,M_HYP,I,4'd11},
        '{I,O,K_NO  ,O,O,O,M_IRQ, F_N,M_HYP,M_HYP,I,4'd11},
        '{I,O,K_NO  ,O,O,I,M_IRQ, F_L,M_IRQ,M_IRQ,I,4'd9},
        '{I,O,K_NO  ,O,I,O,M_HYP, F_L,M_HYP,M_HYP,I,4'd7},
        '{I,O,K_NO  ,O,I,O,M_MON, F_L,M_MON,M_MON,O,4'd7},
        '{O,O,K_NO  ,O,O,I,M_SVC, F_L,M_SVC,M_SVC,O,4'd9},
        '{O,O,K_NO  ,O,I,O,M_HYP, F_P,M_HYP,M_SVC,O,4'd12}, // R12
        '{I,O,K_NO  ,O,O,I,M_HYP, F_P,M_HYP,M_SVC,O,4'd8},
        '{I,I,K_HVC ,O,O,O,M_SVC, F_U,M_HYP,M_SVC,O,4'd3},
        '{O,O,K_NO  ,O,O,I,M_MON, F_L,M_MON,M_MON,O,4'd9},
        '{I,O,K_NO  ,O,O,I,M_MON, F_P,M_MON,M_MON,O,4'd9},
        '{I,O,K_NO  ,O,O,I,M_USR, F_L,M_USR,M_USR,I,4'd9},
        '{I,O,K_SVC ,O,O,O,M_SVC, F_L,M_SVC,M_USR,I,4'd4},
        '{I,O,K_NO  ,O,I,O,M_ABT, F_L,M_ABT,M_ABT,I,4'd7},
        '{I,O,K_NO  ,O,O,I,M_HYP, F_P,M_HYP,M_ABT,I,4'd8}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_ns = 1'b0, cfg_hce = 1'b0;
    logic [NCLS-1:0]   insn_cls = '0;
    logic              subs_imm_zero = 1'b0;
    logic              exc_entry = 1'b0, exc_return = 1'b0;
    logic [MODE_W-1:0] req_mode = M_SVC;
    logic [PRIV_W-1:0] priv;
    logic [MODE_W-1:0] cur_mode, tgt_mode;
    logic              cur_ns, legal, undef, unpred;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mode_guard uut (
        .clk(clk), .rst(rst), .cfg_ns(cfg_ns), .cfg_hce(cfg_hce),
        .insn_cls(insn_cls), .subs_imm_zero(subs_imm_zero),
        .exc_entry(exc_entry), .exc_return(exc_return), .req_mode(req_mode),
        .priv(priv), .cur_mode(cur_mode), .cur_ns(cur_ns),
        .legal(legal), .undef(undef), .unpred(unpred), .tgt_mode(tgt_mode)
    );

    function automatic logic [1:0] exp_priv(input logic [4:0] m);
        if (m == 5'b11010) return 2'd2;
        if (m == 5'b10000) return 2'd0;
        return 2'd1;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        insn_cls = '0; exc_entry = 0; exc_return = 0; subs_imm_zero = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        check(cur_mode == M_SVC, "R1", "mode", 32'(cur_mode), 32'(M_SVC));
        check(cur_ns == 1'b0, "R1", "ns", 32'(cur_ns), 0);
        check(priv == 2'd1, "R1", "priv", 32'(priv), 1);
        // R11 no event, no flag
        check({legal, undef, unpred} == F_N, "R11", "idle flags",
              32'({legal, undef, unpred}), 0);
        check(tgt_mode == cur_mode, "R11", "idle tgt", 32'(tgt_mode), 32'(cur_mode));

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cfg_ns = TBL[k].ns; cfg_hce = TBL[k].hce; insn_cls = TBL[k].cls;
            subs_imm_zero = TBL[k].imm0; exc_entry = TBL[k].ent;
            exc_return = TBL[k].ret; req_mode = TBL[k].req;
            #2;
            check({legal, undef, unpred} == TBL[k].fl,
                  $sformatf("R%0d", TBL[k].tag), $sformatf("flags v%0d", k),
                  32'({legal, undef, unpred}), 32'(TBL[k].fl));
            check(tgt_mode == TBL[k].tgt,
                  $sformatf("R%0d", TBL[k].tag), $sformatf("tgt v%0d", k),
                  32'(tgt_mode), 32'(TBL[k].tgt));
            @(posedge clk);
            #1;
            // R10 state after edge, R2 privilege decode
            check(cur_mode == TBL[k].m_after && cur_ns == TBL[k].ns_after, "R10",
                  $sformatf("state v%0d", k), 32'({cur_ns, cur_mode}),
                  32'({TBL[k].ns_after, TBL[k].m_after}));
            check(priv == exp_priv(TBL[k].m_after), "R2",
                  $sformatf("priv v%0d", k), 32'(priv), 32'(exp_priv(TBL[k].m_after)));
            idle();
        end

        // R1 reset from a non-secure abort state
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        check(cur_mode == M_SVC && cur_ns == 1'b0, "R1", "mid-run reset",
              32'({cur_ns, cur_mode}), 32'({1'b0, M_SVC}));
        @(negedge clk);
        rst = 0;
        // R12 secure entry to Hyp after reset stays put
        exc_entry = 1; req_mode = M_HYP;
        #2;
        check(unpred == 1'b1, "R12", "secure hyp entry", 32'(unpred), 1);
        @(posedge clk);
        #1;
        check(cur_mode == M_SVC, "R12", "secure hyp entry held", 32'(cur_mode), 32'(M_SVC));
        idle();
        // R2 System mode reached by return from Monitor runs at PL1
        @(negedge clk);
        exc_entry = 1; req_mode = M_MON;
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        exc_return = 1; req_mode = M_SYS; cfg_ns = 0;
        @(posedge clk); #1;
        check(cur_mode == M_SYS && priv == 2'd1, "R2", "system priv",
              32'({priv, cur_mode}), 32'({2'd1, M_SYS}));
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule